// File: doc/BRIEF.md
# Base Address Window Decoder

This block keeps the six base address registers and the expansion-ROM register of one configuration-space device. It turns their contents into live decode ranges. Software writes a register through a simple word write port: a byte offset plus 32 data bits. The block masks the value to the window's power-of-two size as it stores it.

Each window's size (as a log2) and, for the six general windows, its space type (I/O or memory) arrive as inputs. So do the I/O-space and memory-space enable bits of the command register. For every window the block reports a valid flag, an effective base and a last address. These follow the stored values and the command bits combinationally.

A probe port compares one address against all windows. It reports whether any valid window of the matching space holds the address, and which one. The lowest index wins when windows overlap.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset every stored register is zero, so every base output is zero, no window is valid and `hit` is low.
- R2: A write with `wr_en` high at offset 0x10 + 4·n (n = 0..5) stores `wr_data` ANDed with ~(size−1) into window n. Offset 0x30 stores into the ROM window (index 6) with the same mask, but bit 0 is kept. A write at any other offset changes no window.
- R3: With size = 2^`bar_size_lg[i]`, the base output is the stored value ANDed with ~(size−1), and the last output is base + size − 1.
- R4: A window whose base is zero, or whose last address is not above its base (a size of 1, or wraparound), is invalid.
- R5: An I/O window whose last address is 0x10000 or higher is invalid.
- R6: An I/O window can be valid only while `cmd_io_en` is 1. A memory window or the ROM window can be valid only while `cmd_mem_en` is 1.
- R7: The ROM window is invalid while bit 0 of its stored value is 0.
- R8: `hit` is 1 exactly when some valid window has a type matching `probe_io` (`probe_io`=1 selects I/O; the ROM window is memory) and has base ≤ `probe_addr` ≤ last. `hit_idx` then gives the lowest such window index, where 0..5 are the general windows and 6 is the ROM window.
- R9: Decode and hit outputs follow the command, size, type and probe inputs in the same cycle with no register between. A stored write is visible from the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ofs | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| bar_size_lg | input | 7x5 | Per-window log2 of window size |
| bar_is_io | input | 6 | Per general window: 1 = I/O, 0 = memory |
| cmd_io_en | input | 1 | I/O-space decode enable |
| cmd_mem_en | input | 1 | Memory-space decode enable |
| probe_addr | input | 32 | Address to test against the windows |
| probe_io | input | 1 | Probe space: 1 = I/O, 0 = memory |
| win_valid | output | 7 | Per-window valid flag |
| win_base | output | 7x32 | Per-window effective base |
| win_last | output | 7x32 | Per-window last address |
| hit | output | 1 | Probe address falls in a valid window |
| hit_idx | output | 3 | Lowest matching window index |

## Verification
A corrupted stored register shows up on `win_base` and `win_last` from the edge after the bad write. The bench reads those outputs after every write, so a wrong mask or a wrong offset decode is caught at the next check. A fault in the validity rules shows as a wrong `win_valid` bit in the same cycle as the input that exposes it. A fault in priority or range compare shows on `hit`/`hit_idx` at once when the bench probes at exact window boundaries and in overlapping windows.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned NUM_BAR  = 6;
  localparam int unsigned NUM_WIN  = NUM_BAR + 1;
  localparam int unsigned SZ_W     = 5;
  localparam int unsigned OFS_W    = 8;
  localparam int unsigned BAR_OFS0 = 'h10;
  localparam int unsigned BAR_STEP = 4;
  localparam int unsigned ROM_OFS  = 'h30;
  localparam longint unsigned IO_LIMIT = 64'h1_0000;
endpackage

// File: rtl/bwd_bar_store.sv
module bwd_bar_store #(
  parameter int unsigned ADDR_W   = bwd_pkg::ADDR_W,
  parameter int unsigned NUM_BAR  = bwd_pkg::NUM_BAR,
  parameter int unsigned SZ_W     = bwd_pkg::SZ_W,
  parameter int unsigned OFS_W    = bwd_pkg::OFS_W,
  parameter int unsigned BAR_OFS0 = bwd_pkg::BAR_OFS0,
  parameter int unsigned BAR_STEP = bwd_pkg::BAR_STEP,
  parameter int unsigned ROM_OFS  = bwd_pkg::ROM_OFS
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [OFS_W-1:0]                    wr_ofs,
  input  logic [ADDR_W-1:0]                   wr_data,
  input  logic [NUM_BAR:0][SZ_W-1:0]          size_lg,
  output logic [NUM_BAR:0][ADDR_W-1:0]        reg_q
);
  localparam int unsigned NUM_WIN = NUM_BAR + 1;
  localparam int unsigned ROM_IDX = NUM_BAR;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [NUM_WIN-1:0]              wr_sel;
  logic [NUM_WIN-1:0][ADDR_W-1:0]  wr_val;
  logic [NUM_WIN-1:0][ADDR_W-1:0]  reg_d;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_WIN; gi++) begin : g_slot
      logic [ADDR_W-1:0] keep_mask;
      assign keep_mask = ~((ONE << size_lg[gi]) - ONE);
      if (gi == ROM_IDX) begin : g_rom
        assign wr_sel[gi] = wr_en && (wr_ofs == OFS_W'(ROM_OFS));
        assign wr_val[gi] = wr_data & (keep_mask | ONE);
      end else begin : g_bar
        assign wr_sel[gi] = wr_en && (wr_ofs == OFS_W'(BAR_OFS0 + BAR_STEP * gi));
        assign wr_val[gi] = wr_data & keep_mask;
      end
    end
  endgenerate

  always_comb begin
    reg_d = reg_q;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (wr_sel[i]) reg_d[i] = wr_val[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= '0;
    else if (wr_en) reg_q <= reg_d;
  end

  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_q));
endmodule

// File: rtl/bwd_win_decode.sv
module bwd_win_decode #(
  parameter int unsigned     ADDR_W   = bwd_pkg::ADDR_W,
  parameter int unsigned     SZ_W     = bwd_pkg::SZ_W,
  parameter longint unsigned IO_LIMIT = bwd_pkg::IO_LIMIT,
  parameter bit              IS_ROM   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_val,
  input  logic [SZ_W-1:0]   size_lg,
  input  logic              is_io,
  input  logic              io_en,
  input  logic              mem_en,
  output logic              valid,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] last
);
  localparam int unsigned XW = ADDR_W + 1;
  localparam logic [XW-1:0]     ONE_X   = XW'(1);
  localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);
  localparam logic [XW-1:0]     LIMIT_X = XW'(IO_LIMIT);

  logic [XW-1:0]     size_x;
  logic [XW-1:0]     sum_x;
  logic [ADDR_W-1:0] mask;
  logic              range_bad;
  logic              io_bad;
  logic              rom_bad;
  logic              space_on;

  always_comb begin
    size_x    = ONE_X << size_lg;
    mask      = ~(size_x[ADDR_W-1:0] - ONE);
    base      = reg_val & mask;
    sum_x     = {1'b0, base} + size_x - ONE_X;
    last      = sum_x[ADDR_W-1:0];
    range_bad = (base == '0) || sum_x[ADDR_W] || (last <= base);
    io_bad    = is_io && (sum_x >= LIMIT_X);
    space_on  = is_io ? io_en : mem_en;
  end

  generate
    if (IS_ROM) begin : g_rom_gate
      assign rom_bad = !reg_val[0];
    end else begin : g_no_rom_gate
      assign rom_bad = 1'b0;
    end
  endgenerate

  assign valid = space_on && !range_bad && !io_bad && !rom_bad;

  assert_space_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (is_io ? io_en : mem_en));
  assert_io_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_io) |-> ({1'b0, last} < LIMIT_X));
  assert_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((last > base) && (base != '0)));
  generate
    if (IS_ROM) begin : g_rom_chk
      assert_rom_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> reg_val[0]);
    end
  endgenerate
endmodule

// File: rtl/bwd_hit_select.sv
module bwd_hit_select #(
  parameter int unsigned ADDR_W  = bwd_pkg::ADDR_W,
  parameter int unsigned NUM_WIN = bwd_pkg::NUM_WIN,
  parameter int unsigned IDX_W   = $clog2(NUM_WIN)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_WIN-1:0]                valid,
  input  logic [NUM_WIN-1:0]                io_type,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]    base,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]    last,
  input  logic [ADDR_W-1:0]                 probe_addr,
  input  logic                              probe_io,
  output logic                              hit,
  output logic [IDX_W-1:0]                  hit_idx
);
  logic [NUM_WIN-1:0] match;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_WIN; gi++) begin : g_cmp
      assign match[gi] = valid[gi] && (io_type[gi] == probe_io) &&
                         (probe_addr >= base[gi]) && (probe_addr <= last[gi]);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |match;

  assert_hit_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (valid[hit_idx] && (probe_addr >= base[hit_idx]) &&
             (probe_addr <= last[hit_idx]) && (io_type[hit_idx] == probe_io)));
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder #(
  parameter int unsigned     ADDR_W   = bwd_pkg::ADDR_W,
  parameter int unsigned     NUM_BAR  = bwd_pkg::NUM_BAR,
  parameter int unsigned     SZ_W     = bwd_pkg::SZ_W,
  parameter int unsigned     OFS_W    = bwd_pkg::OFS_W,
  parameter longint unsigned IO_LIMIT = bwd_pkg::IO_LIMIT,
  parameter int unsigned     IDX_W    = $clog2(NUM_BAR + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [OFS_W-1:0]               wr_ofs,
  input  logic [ADDR_W-1:0]              wr_data,
  input  logic [NUM_BAR:0][SZ_W-1:0]     bar_size_lg,
  input  logic [NUM_BAR-1:0]             bar_is_io,
  input  logic                           cmd_io_en,
  input  logic                           cmd_mem_en,
  input  logic [ADDR_W-1:0]              probe_addr,
  input  logic                           probe_io,
  output logic [NUM_BAR:0]               win_valid,
  output logic [NUM_BAR:0][ADDR_W-1:0]   win_base,
  output logic [NUM_BAR:0][ADDR_W-1:0]   win_last,
  output logic                           hit,
  output logic [IDX_W-1:0]               hit_idx
);
  localparam int unsigned NUM_WIN = NUM_BAR + 1;
  localparam int unsigned ROM_IDX = NUM_BAR;

  logic [NUM_WIN-1:0][ADDR_W-1:0] reg_q;
  logic [NUM_WIN-1:0]             io_type;

  bwd_bar_store #(
    .ADDR_W(ADDR_W), .NUM_BAR(NUM_BAR), .SZ_W(SZ_W), .OFS_W(OFS_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(wr_ofs),
    .wr_data(wr_data), .size_lg(bar_size_lg), .reg_q(reg_q)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_WIN; gi++) begin : g_win
      if (gi == ROM_IDX) begin : g_type_rom
        assign io_type[gi] = 1'b0;
      end else begin : g_type_bar
        assign io_type[gi] = bar_is_io[gi];
      end
      bwd_win_decode #(
        .ADDR_W(ADDR_W), .SZ_W(SZ_W), .IO_LIMIT(IO_LIMIT),
        .IS_ROM(gi == ROM_IDX)
      ) u_dec (
        .clk(clk), .rst_n(rst_n), .reg_val(reg_q[gi]),
        .size_lg(bar_size_lg[gi]), .is_io(io_type[gi]),
        .io_en(cmd_io_en), .mem_en(cmd_mem_en),
        .valid(win_valid[gi]), .base(win_base[gi]), .last(win_last[gi])
      );
    end
  endgenerate

  bwd_hit_select #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .IDX_W(IDX_W)
  ) u_hit (
    .clk(clk), .rst_n(rst_n), .valid(win_valid), .io_type(io_type),
    .base(win_base), .last(win_last), .probe_addr(probe_addr),
    .probe_io(probe_io), .hit(hit), .hit_idx(hit_idx)
  );

  assert_disabled_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (probe_io ? cmd_io_en : cmd_mem_en));
endmodule

// File: tb/bar_window_decoder_tb.sv
module bar_window_decoder_tb;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [7:0]        wr_ofs;
  logic [31:0]       wr_data;
  logic [6:0][4:0]   bar_size_lg;
  logic [5:0]        bar_is_io;
  logic              cmd_io_en, cmd_mem_en;
  logic [31:0]       probe_addr;
  logic              probe_io;
  logic [6:0]        win_valid;
  logic [6:0][31:0]  win_base, win_last;
  logic              hit;
  logic [2:0]        hit_idx;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  bar_window_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
    .bar_size_lg(bar_size_lg), .bar_is_io(bar_is_io), .cmd_io_en(cmd_io_en),
    .cmd_mem_en(cmd_mem_en), .probe_addr(probe_addr), .probe_io(probe_io),
    .win_valid(win_valid), .win_base(win_base), .win_last(win_last),
    .hit(hit), .hit_idx(hit_idx)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_ofs = ofs; wr_data = data;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic probe(input logic [31:0] a, input logic io, input string req,
                       input logic exp_hit, input logic [2:0] exp_idx);
    probe_addr = a; probe_io = io;
    #1;
    chk(req, "hit", {31'd0, hit}, {31'd0, exp_hit});
    if (exp_hit) chk(req, "hit_idx", {29'd0, hit_idx}, {29'd0, exp_idx});
  endtask

  task automatic t_reset;
    chk("R1", "valid after reset", {25'd0, win_valid}, 32'd0);
    for (int i = 0; i < 7; i++) chk("R1", "base after reset", win_base[i], 32'd0);
    probe(32'd0, 1'b0, "R1", 1'b0, 3'd0);
  endtask

  task automatic t_mem_window;
    wr(8'h10, 32'h8000_0ABC);
    chk("R2", "win0 base", win_base[0], 32'h8000_0000);
    chk("R3", "win0 last", win_last[0], 32'h8000_0FFF);
    chk("R6", "win0 valid mem on", {31'd0, win_valid[0]}, 32'd1);
    cmd_mem_en = 1'b0; #1;
    chk("R9", "win0 valid mem off same cycle", {31'd0, win_valid[0]}, 32'd0);
    cmd_mem_en = 1'b1; #1;
  endtask

  task automatic t_io_window;
    wr(8'h14, 32'h0000_C05F);
    chk("R3", "win1 base", win_base[1], 32'h0000_C050);
    chk("R3", "win1 last", win_last[1], 32'h0000_C05F);
    chk("R6", "win1 valid io on", {31'd0, win_valid[1]}, 32'd1);
    cmd_io_en = 1'b0; #1;
    chk("R6", "win1 valid io off", {31'd0, win_valid[1]}, 32'd0);
    cmd_io_en = 1'b1; #1;
    wr(8'h14, 32'h0000_FFF3);
    chk("R5", "win1 last at top", win_last[1], 32'h0000_FFFF);
    chk("R5", "win1 valid below limit", {31'd0, win_valid[1]}, 32'd1);
    wr(8'h14, 32'h0001_0000);
    chk("R5", "win1 valid at limit", {31'd0, win_valid[1]}, 32'd0);
    wr(8'h14, 32'h0000_C050);
  endtask

  task automatic t_degenerate;
    wr(8'h18, 32'h0000_0077);
    chk("R4", "win2 zero base", win_base[2], 32'd0);
    chk("R4", "win2 valid zero base", {31'd0, win_valid[2]}, 32'd0);
    wr(8'h1C, 32'h0000_1234);
    chk("R4", "win3 last size1", win_last[3], 32'h0000_1234);
    chk("R4", "win3 valid size1", {31'd0, win_valid[3]}, 32'd0);
  endtask

  task automatic t_rom;
    wr(8'h30, 32'h000A_0000);
    chk("R7", "rom valid no enable bit", {31'd0, win_valid[6]}, 32'd0);
    wr(8'h30, 32'h000A_FFFF);
    chk("R2", "rom base", win_base[6], 32'h000A_0000);
    chk("R3", "rom last", win_last[6], 32'h000A_FFFF);
    chk("R7", "rom valid enable bit", {31'd0, win_valid[6]}, 32'd1);
    cmd_mem_en = 1'b0; #1;
    chk("R6", "rom valid mem off", {31'd0, win_valid[6]}, 32'd0);
    cmd_mem_en = 1'b1; #1;
  endtask

  task automatic t_ignored;
    wr(8'h2C, 32'hDEAD_BEEF);
    wr(8'h34, 32'hDEAD_BEEF);
    wr(8'h11, 32'hDEAD_BEEF);
    chk("R2", "win0 kept", win_base[0], 32'h8000_0000);
    chk("R2", "win1 kept", win_base[1], 32'h0000_C050);
    chk("R2", "win4 kept", win_base[4], 32'd0);
    chk("R2", "win5 kept", win_base[5], 32'd0);
    chk("R2", "rom kept", win_base[6], 32'h000A_0000);
  endtask

  task automatic t_hits;
    wr(8'h20, 32'h8000_0155);
    chk("R3", "win4 base", win_base[4], 32'h8000_0100);
    wr(8'h24, 32'h0000_C000);
    probe(32'h8000_0150, 1'b0, "R8", 1'b1, 3'd0);
    probe(32'h8000_0FFF, 1'b0, "R8", 1'b1, 3'd0);
    probe(32'h8000_1000, 1'b0, "R8", 1'b0, 3'd0);
    probe(32'h8000_0150, 1'b1, "R8", 1'b0, 3'd0);
    probe(32'h0000_C055, 1'b1, "R8", 1'b1, 3'd1);
    probe(32'h0000_C000, 1'b1, "R8", 1'b1, 3'd5);
    probe(32'h000A_FFFF, 1'b0, "R8", 1'b1, 3'd6);
    cmd_io_en = 1'b0;
    probe(32'h0000_C055, 1'b1, "R6", 1'b0, 3'd0);
    cmd_io_en = 1'b1; cmd_mem_en = 1'b0;
    probe(32'h000A_1000, 1'b0, "R6", 1'b0, 3'd0);
    cmd_mem_en = 1'b1;
  endtask

  task automatic t_size_change;
    bar_size_lg[0] = 5'd8; #1;
    chk("R9", "win0 last after size change", win_last[0], 32'h8000_00FF);
    bar_size_lg[0] = 5'd12; #1;
    chk("R9", "win0 last restored", win_last[0], 32'h8000_0FFF);
  endtask

  initial begin
    #150000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_ofs = '0; wr_data = '0;
    bar_size_lg = {5'd16, 5'd8, 5'd8, 5'd0, 5'd8, 5'd4, 5'd12};
    bar_is_io = 6'b100010;
    cmd_io_en = 1'b1; cmd_mem_en = 1'b1;
    probe_addr = '0; probe_io = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_mem_window();
    t_io_window();
    t_degenerate();
    t_rom();
    t_ignored();
    t_hits();
    t_size_change();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule